// File: doc/BRIEF.md
# Video Interrupt Priority Controller

This block turns two interrupt requests from a video timing generator, one at the start of vertical blanking and one per horizontal line, into an encoded priority level for a main processor that holds a 3-bit interrupt mask. The vertical source is presented at level 6 and the horizontal source at level 4. Each source is latched as pending on the rising edge of its request strobe. A pending source is only shown on the level output while the processor mask is below that source's level. When the processor acknowledges, the source whose level is currently shown is cleared.

Alongside this, the block drives an interrupt line to a secondary processor. That line goes high at each vertical event and stays high for a fixed number of the secondary processor's clock ticks. A tick-enable input marks each of those ticks.

Top module: `vid_irq_prio`

## Requirements
- R1: While reset is low and in the first cycle after it, `cpuIpl` is 0 and `subInt` is 0, and neither source is pending.
- R2: A source becomes pending only on a rising edge of its request strobe (a low-to-high change between two clock samples). Holding a strobe high after its pending flag is acknowledged does not set the flag again.
- R3: A pending vertical source gives `cpuIpl` = 6 while `cpuMask` < 6. With `cpuMask` of 6 or 7 the vertical source is not shown and `cpuIpl` is 0.
- R4: A pending horizontal source gives `cpuIpl` = 4 only while `cpuMask` < 4. It is never shown while the vertical source is pending and unmasked.
- R5: When both sources are pending and `cpuMask` < 4, `cpuIpl` is 6. `cpuIpl` only ever takes the values 0, 4 and 6.
- R6: A pending flag stays set while its source is masked. `cpuIpl` is registered: it reflects the mask and pending state of the previous clock edge, so it changes one clock after `cpuMask` changes.
- R7: An `intAck` pulse clears the pending flag of the source whose level `cpuIpl` shows in that cycle. The other source stays pending. An `intAck` while `cpuIpl` is 0 clears nothing.
- R8: A vertical rising edge sets `subInt` high from the next cycle. `subInt` stays high for exactly 128 cycles in which `subTick` is high, then goes low.
- R9: A vertical rising edge while `subInt` is already high restarts the full 128-tick count.
- R10: If a rising edge of a source coincides with an acknowledge of that same source, the source remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vblankReq | input | 1 | Vertical interrupt request strobe |
| hblankReq | input | 1 | Horizontal interrupt request strobe |
| cpuMask | input | 3 | Current interrupt mask of the main processor |
| intAck | input | 1 | Acknowledge pulse from the main processor |
| subTick | input | 1 | Clock-enable marking one secondary processor clock |
| cpuIpl | output | 3 | Encoded interrupt priority level (0, 4 or 6) |
| subInt | output | 1 | Interrupt line to the secondary processor, active high |

## Verification
The hardest case to reach is a new edge landing on the same source in exactly the cycle that source is being acknowledged. It needs the registered level to already show that source when the strobe rises. The stimulus first parks a pending vertical source at level 6, then drives the acknowledge and a fresh vertical edge on the same clock. The restart of the secondary pulse is reached by issuing a second vertical edge deep inside a running pulse. Constrained random mask, strobe, acknowledge and tick traffic is then compared every cycle against a reference model in the bench.

// File: rtl/vip_pkg.sv
package vip_pkg;
  typedef struct packed {
    logic vSet;
    logic hSet;
    logic vClr;
    logic hClr;
    logic pulseLoad;
  } vipStrobe_t;
endpackage

// File: rtl/vip_ctrl.sv
module vip_ctrl
  import vip_pkg::*;
#(
  parameter int MASK_W  = 3,
  parameter int V_LEVEL = 6,
  parameter int H_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankReq,
  input  logic              hblankReq,
  input  logic              intAck,
  input  logic [MASK_W-1:0] iplNow,
  output vipStrobe_t        strobe
);
  localparam logic [MASK_W-1:0] V_CODE = MASK_W'(V_LEVEL);
  localparam logic [MASK_W-1:0] H_CODE = MASK_W'(H_LEVEL);

  logic vDly, hDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vDly <= 1'b0;
      hDly <= 1'b0;
    end else begin
      vDly <= vblankReq;
      hDly <= hblankReq;
    end
  end

  always_comb begin
    strobe.vSet      = vblankReq & ~vDly;
    strobe.hSet      = hblankReq & ~hDly;
    strobe.pulseLoad = vblankReq & ~vDly;
    strobe.vClr      = intAck && (iplNow == V_CODE);
    strobe.hClr      = intAck && (iplNow == H_CODE);
  end
endmodule

// File: rtl/vip_datapath.sv
module vip_datapath
  import vip_pkg::*;
#(
  parameter int MASK_W    = 3,
  parameter int V_LEVEL   = 6,
  parameter int H_LEVEL   = 4,
  parameter int PULSE_LEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  vipStrobe_t        strobe,
  input  logic [MASK_W-1:0] cpuMask,
  input  logic              subTick,
  output logic [MASK_W-1:0] iplOut,
  output logic              subInt
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [MASK_W-1:0] V_CODE = MASK_W'(V_LEVEL);
  localparam logic [MASK_W-1:0] H_CODE = MASK_W'(H_LEVEL);
  localparam logic [CNT_W-1:0]  LEN_CODE = CNT_W'(PULSE_LEN);

  logic              vPend, hPend;
  logic [MASK_W-1:0] iplNext;
  logic [CNT_W-1:0]  pulseCnt;

  always_comb begin
    iplNext = '0;
    if (cpuMask < V_CODE) begin
      if (vPend) iplNext = V_CODE;
      else if (hPend && (cpuMask < H_CODE)) iplNext = H_CODE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPend    <= 1'b0;
      hPend    <= 1'b0;
      iplOut   <= '0;
      pulseCnt <= '0;
    end else begin
      if (strobe.vSet)      vPend <= 1'b1;
      else if (strobe.vClr) vPend <= 1'b0;
      if (strobe.hSet)      hPend <= 1'b1;
      else if (strobe.hClr) hPend <= 1'b0;
      iplOut <= iplNext;
      if (strobe.pulseLoad)                 pulseCnt <= LEN_CODE;
      else if (subTick && pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign subInt = (pulseCnt != '0);
endmodule

// File: rtl/vid_irq_prio.sv
module vid_irq_prio
  import vip_pkg::*;
#(
  parameter int MASK_W    = 3,
  parameter int V_LEVEL   = 6,
  parameter int H_LEVEL   = 4,
  parameter int PULSE_LEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankReq,
  input  logic              hblankReq,
  input  logic [MASK_W-1:0] cpuMask,
  input  logic              intAck,
  input  logic              subTick,
  output logic [MASK_W-1:0] cpuIpl,
  output logic              subInt
);
  vipStrobe_t strobe;

  vip_ctrl #(.MASK_W(MASK_W), .V_LEVEL(V_LEVEL), .H_LEVEL(H_LEVEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .vblankReq(vblankReq), .hblankReq(hblankReq),
    .intAck(intAck), .iplNow(cpuIpl), .strobe(strobe)
  );

  vip_datapath #(.MASK_W(MASK_W), .V_LEVEL(V_LEVEL), .H_LEVEL(H_LEVEL),
                 .PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuMask(cpuMask),
    .subTick(subTick), .iplOut(cpuIpl), .subInt(subInt)
  );
endmodule

// File: rtl/vid_irq_prio_chk.sv
module vid_irq_prio_chk #(
  parameter int MASK_W  = 3,
  parameter int V_LEVEL = 6,
  parameter int H_LEVEL = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              vblankReq,
  input logic [MASK_W-1:0] cpuMask,
  input logic              subTick,
  input logic [MASK_W-1:0] cpuIpl,
  input logic              subInt
);
  localparam logic [MASK_W-1:0] V_CODE = MASK_W'(V_LEVEL);
  localparam logic [MASK_W-1:0] H_CODE = MASK_W'(H_LEVEL);

  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (cpuIpl == '0 && !subInt);
    end
  end

  a_r3_v_needs_low_mask: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIpl == V_CODE) |-> ($past(cpuMask) < V_CODE));

  a_r4_h_needs_low_mask: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIpl == H_CODE) |-> ($past(cpuMask) < H_CODE));

  a_r5_level_legal: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIpl == '0) || (cpuIpl == V_CODE) || (cpuIpl == H_CODE));

  a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    (vblankReq && !$past(vblankReq)) |=> subInt);

  a_r8_pulse_hold: assert property (@(posedge clk) disable iff (!rstN)
    (subInt && !subTick) |=> subInt);
endmodule

bind vid_irq_prio vid_irq_prio_chk #(.MASK_W(MASK_W), .V_LEVEL(V_LEVEL), .H_LEVEL(H_LEVEL)) u_chk (
  .clk(clk), .rstN(rstN), .vblankReq(vblankReq), .cpuMask(cpuMask),
  .subTick(subTick), .cpuIpl(cpuIpl), .subInt(subInt)
);

// File: tb/tb_vid_irq_prio.sv
module tb_vid_irq_prio;
  localparam int LEN = 128;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vblankReq = 1'b0, hblankReq = 1'b0, intAck = 1'b0, subTick = 1'b1;
  logic [2:0] cpuMask = 3'd7;
  logic [2:0] cpuIpl;
  logic       subInt;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  vid_irq_prio dut (
    .clk(clk), .rstN(rstN), .vblankReq(vblankReq), .hblankReq(hblankReq),
    .cpuMask(cpuMask), .intAck(intAck), .subTick(subTick),
    .cpuIpl(cpuIpl), .subInt(subInt)
  );

  always #4 clk = ~clk;

  // reference model built from the requirements
  logic       mV, mH, mVd, mHd;
  logic [2:0] mIpl;
  int         mCnt;

  function automatic logic [2:0] prio(logic v, logic h, logic [2:0] m);
    if (m < 3'd6 && v) return 3'd6;
    if (m < 3'd4 && h) return 3'd4;
    return 3'd0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mV <= 0; mH <= 0; mVd <= 0; mHd <= 0; mIpl <= 0; mCnt <= 0;
    end else begin
      mVd <= vblankReq;
      mHd <= hblankReq;
      if (vblankReq && !mVd) mV <= 1;
      else if (intAck && mIpl == 3'd6) mV <= 0;
      if (hblankReq && !mHd) mH <= 1;
      else if (intAck && mIpl == 3'd4) mH <= 0;
      mIpl <= prio(mV, mH, cpuMask);
      if (vblankReq && !mVd) mCnt <= LEN;
      else if (subTick && mCnt > 0) mCnt <= mCnt - 1;
    end
  end

  task automatic expectEq(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expectEq(cpuIpl, mIpl, "R6 model level");
      expectEq(subInt, mCnt != 0, "R8 model pulse");
    end
  endtask

  task automatic pulseV();
    vblankReq = 1; step(1); vblankReq = 0;
  endtask
  task automatic pulseH();
    hblankReq = 1; step(1); hblankReq = 0;
  endtask
  task automatic ack();
    intAck = 1; step(1); intAck = 0;
  endtask

  task automatic countPulse(string tag);
    int n = 0;
    vblankReq = 1;
    @(negedge clk);
    vblankReq = 0;
    while (subInt && n < 1000) begin
      n++;
      @(negedge clk);
    end
    expectEq(n, LEN, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectEq(cpuIpl, 0, "R1 ipl in reset");
    expectEq(subInt, 0, "R1 subInt in reset");
    rstN = 1;
    step(1);
    expectEq(cpuIpl, 0, "R1 ipl after reset");

    // R3: masked vertical
    cpuMask = 3'd6; pulseV(); step(3);
    expectEq(cpuIpl, 0, "R3 mask 6 blocks vertical");
    expectEq(subInt, 1, "R8 pulse running");
    cpuMask = 3'd5; step(1);
    expectEq(cpuIpl, 6, "R6 level one clock after mask change");
    expectEq(cpuIpl, 6, "R3 vertical at level 6");
    ack(); step(3);
    expectEq(cpuIpl, 0, "R7 ack clears vertical");

    // R4: horizontal
    cpuMask = 3'd4; pulseH(); step(3);
    expectEq(cpuIpl, 0, "R4 mask 4 blocks horizontal");
    cpuMask = 3'd3; step(2);
    expectEq(cpuIpl, 4, "R4 horizontal at level 4");

    // R5: both pending
    pulseV(); step(3);
    expectEq(cpuIpl, 6, "R5 vertical wins");
    ack(); step(3);
    expectEq(cpuIpl, 4, "R7 other source stays pending");
    ack(); step(3);
    expectEq(cpuIpl, 0, "R7 second ack clears horizontal");
    ack(); step(2);
    expectEq(cpuIpl, 0, "R7 ack at level 0 no effect");
    cpuMask = 3'd0; step(2);
    expectEq(cpuIpl, 0, "R7 nothing revived by idle ack");

    // R2: held strobe
    hblankReq = 1; step(3);
    expectEq(cpuIpl, 4, "R2 held strobe pends once");
    ack(); step(4);
    expectEq(cpuIpl, 0, "R2 held strobe not re-pended");
    hblankReq = 0; step(2);

    // R10: edge coinciding with ack
    pulseV(); step(3);
    expectEq(cpuIpl, 6, "R10 setup");
    intAck = 1; vblankReq = 1; step(1);
    intAck = 0; vblankReq = 0; step(3);
    expectEq(cpuIpl, 6, "R10 new edge survives ack");
    ack(); step(3);
    expectEq(cpuIpl, 0, "R10 cleared afterwards");

    // R8 / R9: pulse length and restart
    while (subInt) step(1);
    cpuMask = 3'd7;
    countPulse("R8 pulse lasts 128 ticks");
    pulseV(); step(60);
    countPulse("R9 pulse restarts on new edge");
    cpuMask = 3'd0; step(2); ack(); step(3);

    // constrained random traffic against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      cpuMask   = 3'($urandom_range(0, 7));
      vblankReq = ($urandom_range(0, 99) < 3);
      hblankReq = ($urandom_range(0, 99) < 10);
      intAck    = ($urandom_range(0, 99) < 15);
      subTick   = ($urandom_range(0, 99) < 60);
      step(1);
    end
    vblankReq = 0; hblankReq = 0; intAck = 0;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule